// File: doc/BRIEF.md
# Register-Mapped GPIO Bank with Pin Interrupts

This block is a bank of general-purpose pins behind a simple word-wide register bus. Software picks, pin by pin, whether the block drives the pin, reads the synchronised level of every pin, and changes the output latch only through two strobe registers. One register raises bits of the latch and the other lowers them, so no read-modify-write of the latch is ever needed.

Each pin can also raise an interrupt. A type bit picks level or edge sensing, and a polarity bit picks high/rising or low/falling. An enable bit decides whether a pin's events are recorded in the pending register at all. A separate mask bit decides whether a recorded event reaches the single registered interrupt line. Only one edge direction is sensed at a time. Software gets both-edge behaviour by rewriting the polarity to the inverse of the present input level each time it services an event.

The bus carries a word index rather than a byte address, so index k stands for byte offset 4*k. Reads return data one cycle after the read strobe.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every pin is an input (pin_oe all zero), the output latch is zero, no interrupt is pending and irq_o is low.
- R2: A write of data d to index 3 (byte offset 0x0C) sets the latch bits where d is 1. A write to index 4 (0x10) clears the latch bits where d is 1. Zero bits of d leave the latch unchanged. Index 2 (0x08) reads the latch back.
- R3: Index 0 (0x00) holds the direction register. With INV_DIR=0 a 1 bit drives the pin (pin_oe=1). With INV_DIR=1 a 1 bit makes it an input.
- R4: Index 1 (0x04) reads the pin levels after a two-flop synchroniser.
- R5: Register bits at or above PIN_CNT read as zero, and PIN_CNT must lie between 1 and 31.
- R6: Writes to indices 1 and 2 change nothing. Reads of indices 3 and 4, and of any index above 9, return zero.
- R7: The interrupt type register is at index 6 (0x18), with 0 selecting edge sensing. The polarity register is at index 7 (0x1C), with 1 selecting rising and 0 selecting falling. An edge is a change between two consecutive synchronised samples, so software can follow both edges by flipping the polarity after each event.
- R8: An edge-type pending bit (index 8, 0x20) stays set until software writes 1 to it. If a new edge arrives in the same cycle as the clear, the bit stays set.
- R9: With type 1 (level sensing), the pending bit follows the enabled level: high when polarity is 1, low when polarity is 0. Writes to that bit have no effect.
- R10: A pin whose enable bit (index 5, 0x14) is 0 records no new pending event.
- R11: irq_o is a register equal to the OR over all pins of (pending AND mask). The mask register is at index 9 (0x24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_idx | input | 4 | Word index of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | PIN_CNT | Write data, one bit per pin |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pin_in | input | PIN_CNT | Pin levels from the pads |
| pin_out | output | PIN_CNT | Output latch |
| pin_oe | output | PIN_CNT | Per-pin drive enable |
| irq_o | output | 1 | Combined interrupt line |

## Verification
A wrong pending bit shows up in two places: when index 8 is read back, and on irq_o one cycle later if that pin is masked in. A pin change reaches pending three clock edges after it arrives and reaches irq_o on the fourth, so a lost or spurious event is visible within a handful of cycles. A latch or direction fault shows on pin_out or pin_oe in the cycle right after the write. A decode fault shows up as a read-back value that differs from what was written.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int unsigned IDX_W  = 4;
   localparam int unsigned RD_W   = 32;

   typedef enum logic [IDX_W-1:0] {
      IDX_DIR   = 4'd0,
      IDX_IN    = 4'd1,
      IDX_OUT   = 4'd2,
      IDX_SET   = 4'd3,
      IDX_CLR   = 4'd4,
      IDX_IEN   = 4'd5,
      IDX_ITYPE = 4'd6,
      IDX_IPOL  = 4'd7,
      IDX_PEND  = 4'd8,
      IDX_MASK  = 4'd9
   } gpio_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync needs at least two stages");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain_q[s] <= '0;
         else if (s == 0) chain_q[s] <= d_i;
         else             chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = chain_q[LAST];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int unsigned PIN_CNT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PIN_CNT-1:0] smp_i,
   input  logic [PIN_CNT-1:0] ien_i,
   input  logic [PIN_CNT-1:0] itype_i,
   input  logic [PIN_CNT-1:0] ipol_i,
   input  logic [PIN_CNT-1:0] clr_i,
   output logic [PIN_CNT-1:0] pend_o
);
   logic [PIN_CNT-1:0] prev_q;
   logic [PIN_CNT-1:0] pend_q;
   logic [PIN_CNT-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= smp_i;
   end

   for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
      logic lvl_hit, edge_hit;
      assign lvl_hit  = ipol_i[p] ? smp_i[p] : ~smp_i[p];
      assign edge_hit = ipol_i[p] ? (smp_i[p] & ~prev_q[p])
                                  : (~smp_i[p] & prev_q[p]);
      assign hit[p]   = itype_i[p] ? lvl_hit : edge_hit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pend_q[p] <= 1'b0;
         else if (itype_i[p]) pend_q[p] <= ien_i[p] & hit[p];
         else                 pend_q[p] <= (pend_q[p] & ~clr_i[p]) | (ien_i[p] & hit[p]);
      end
   end

   assign pend_o = pend_q;

   // R8: edge-type pending bits are held until cleared by software
   p_edge_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pend_q & ~itype_i & ~clr_i) & ~pend_q) == '0));

   // R10: a disabled pin with nothing pending cannot become pending
   p_gate_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(~ien_i & ~pend_q) & pend_q) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int unsigned PIN_CNT = 8,
   parameter bit          INV_DIR = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   bus_idx,
   input  logic               bus_wr,
   input  logic [PIN_CNT-1:0] bus_wdata,
   input  logic               bus_rd,
   output logic [RD_W-1:0]    bus_rdata,
   input  logic [PIN_CNT-1:0] pin_in,
   output logic [PIN_CNT-1:0] pin_out,
   output logic [PIN_CNT-1:0] pin_oe,
   output logic               irq_o
);
   localparam logic [PIN_CNT-1:0] DIR_RST = INV_DIR ? '1 : '0;

   if (PIN_CNT < 1 || PIN_CNT > 31) begin : g_bad_cnt
      $error("PIN_CNT must be between 1 and 31");
   end

   logic [PIN_CNT-1:0] dir_q, out_q, ien_q, itype_q, ipol_q, mask_q;
   logic [PIN_CNT-1:0] smp, pend, pend_clr, rd_mux;
   logic [RD_W-1:0]    rdata_q;
   logic               irq_q;

   function automatic logic hit_idx(input logic [IDX_W-1:0] a, input gpio_idx_e r);
      return a == r;
   endfunction

   // write side
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= DIR_RST;
         out_q   <= '0;
         ien_q   <= '0;
         itype_q <= '0;
         ipol_q  <= '0;
         mask_q  <= '0;
      end else if (bus_wr) begin
         if (hit_idx(bus_idx, IDX_DIR))   dir_q   <= bus_wdata;
         if (hit_idx(bus_idx, IDX_SET))   out_q   <= out_q | bus_wdata;
         if (hit_idx(bus_idx, IDX_CLR))   out_q   <= out_q & ~bus_wdata;
         if (hit_idx(bus_idx, IDX_IEN))   ien_q   <= bus_wdata;
         if (hit_idx(bus_idx, IDX_ITYPE)) itype_q <= bus_wdata;
         if (hit_idx(bus_idx, IDX_IPOL))  ipol_q  <= bus_wdata;
         if (hit_idx(bus_idx, IDX_MASK))  mask_q  <= bus_wdata;
      end
   end

   assign pend_clr = (bus_wr && hit_idx(bus_idx, IDX_PEND)) ? bus_wdata : '0;

   gpio_sync #(.WIDTH(PIN_CNT), .STAGES(2)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_in),
      .q_o   (smp)
   );

   gpio_irq_detect #(.PIN_CNT(PIN_CNT)) det_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_i   (smp),
      .ien_i   (ien_q),
      .itype_i (itype_q),
      .ipol_i  (ipol_q),
      .clr_i   (pend_clr),
      .pend_o  (pend)
   );

   // read side
   always_comb begin
      case (bus_idx)
         IDX_DIR:   rd_mux = dir_q;
         IDX_IN:    rd_mux = smp;
         IDX_OUT:   rd_mux = out_q;
         IDX_IEN:   rd_mux = ien_q;
         IDX_ITYPE: rd_mux = itype_q;
         IDX_IPOL:  rd_mux = ipol_q;
         IDX_PEND:  rd_mux = pend;
         IDX_MASK:  rd_mux = mask_q;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= RD_W'(rd_mux);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(pend & mask_q);
   end

   if (INV_DIR) begin : g_dir_inv
      assign pin_oe = ~dir_q;
   end else begin : g_dir_std
      assign pin_oe = dir_q;
   end

   assign pin_out   = out_q;
   assign bus_rdata = rdata_q;
   assign irq_o     = irq_q;

   // R2: set strobe raises every requested bit
   p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_idx == IDX_SET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

   // R2: clear strobe lowers every requested bit
   p_clr_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_idx == IDX_CLR) |=> ((pin_out & $past(bus_wdata)) == '0));

   // R5: nothing above the pin count ever reaches the bus
   p_hi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata >> PIN_CNT) == '0);

   // R11: the line only rises for a masked-in pending pin
   p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(|(pend & mask_q)));
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
   localparam int N = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    bus_idx = '0;
   logic          bus_wr = 1'b0;
   logic [N-1:0]  bus_wdata = '0;
   logic          bus_rd = 1'b0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  pin_in = '0;
   logic [N-1:0]  pin_out, pin_oe;
   logic          irq_o;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   gpio_irq_ctrl #(.PIN_CNT(N), .INV_DIR(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_idx(bus_idx), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] idx, input logic [N-1:0] d);
      @(negedge clk);
      bus_idx = idx; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] idx, output logic [31:0] d);
      @(negedge clk);
      bus_idx = idx; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic quiet();
      wr(4'd5, '0); wr(4'd9, '0); wr(4'd6, '0); wr(4'd7, '0);
      pin_in = '0;
      wait_cyc(4);
      wr(4'd8, '1);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 pin_oe", 32'(pin_oe), 0);
      chk("R1 pin_out", 32'(pin_out), 0);
      chk("R1 irq_o", 32'(irq_o), 0);
      rd(4'd8, v); chk("R1 pending", v, 0);
   endtask

   task automatic t_latch();
      logic [31:0] v;
      wr(4'd3, 8'hA5); chk("R2 set", 32'(pin_out), 32'hA5);
      wr(4'd4, 8'h05); chk("R2 clear", 32'(pin_out), 32'hA0);
      wr(4'd3, 8'h00); chk("R2 zero set", 32'(pin_out), 32'hA0);
      rd(4'd2, v);     chk("R2 readback", v, 32'hA0);
   endtask

   task automatic t_dir();
      logic [31:0] v;
      wr(4'd0, 8'h0F); chk("R3 oe", 32'(pin_oe), 32'h0F);
      rd(4'd0, v);     chk("R3 readback", v, 32'h0F);
      wr(4'd0, 8'hFF); rd(4'd0, v); chk("R5 upper zero", v, 32'hFF);
   endtask

   task automatic t_input();
      logic [31:0] v;
      pin_in = 8'h3C; wait_cyc(3);
      rd(4'd1, v); chk("R4 input", v, 32'h3C);
      wr(4'd1, 8'h00); rd(4'd1, v); chk("R6 input ro", v, 32'h3C);
      wr(4'd2, 8'hFF); chk("R6 latch ro", 32'(pin_out), 32'hA0);
      rd(4'd3, v);  chk("R6 set reads 0", v, 0);
      rd(4'd12, v); chk("R6 unmapped", v, 0);
      pin_in = '0;
   endtask

   task automatic t_edge_rise();
      logic [31:0] v;
      quiet();
      wr(4'd7, 8'h01); wr(4'd5, 8'h01); wr(4'd9, 8'h01);
      pin_in[0] = 1'b1; wait_cyc(6);
      chk("R7 rise irq", 32'(irq_o), 1);
      rd(4'd8, v); chk("R7 rise pend", v, 1);
      pin_in[0] = 1'b0; wait_cyc(6);
      rd(4'd8, v); chk("R8 sticky", v, 1);
      wr(4'd8, 8'h01); wait_cyc(2);
      rd(4'd8, v); chk("R8 w1c", v, 0);
      chk("R11 irq drop", 32'(irq_o), 0);
   endtask

   task automatic t_both_sw();
      logic [31:0] v;
      quiet();
      wr(4'd7, 8'h01); wr(4'd5, 8'h01);
      pin_in[0] = 1'b1; wait_cyc(6);
      rd(4'd8, v); chk("R7 both first", v, 1);
      wr(4'd7, 8'h00); wr(4'd8, 8'h01);
      rd(4'd8, v); chk("R7 both cleared", v, 0);
      pin_in[0] = 1'b0; wait_cyc(6);
      rd(4'd8, v); chk("R7 both second", v, 1);
   endtask

   task automatic t_edge_fall();
      logic [31:0] v;
      quiet();
      pin_in[1] = 1'b1; wait_cyc(4);
      wr(4'd5, 8'h02);
      rd(4'd8, v); chk("R7 fall idle", v, 0);
      pin_in[1] = 1'b0; wait_cyc(6);
      rd(4'd8, v); chk("R7 fall pend", v, 2);
   endtask

   task automatic t_level();
      logic [31:0] v;
      quiet();
      wr(4'd6, 8'h0C); wr(4'd7, 8'h04); wr(4'd5, 8'h0C); wr(4'd9, 8'h0C);
      pin_in = 8'h08; wait_cyc(4);
      rd(4'd8, v); chk("R9 idle", v, 0);
      pin_in = 8'h0C; wait_cyc(4);
      rd(4'd8, v); chk("R9 high", v, 4);
      wr(4'd8, 8'h04); rd(4'd8, v); chk("R9 w1c ignored", v, 4);
      pin_in = 8'h00; wait_cyc(5);
      rd(4'd8, v); chk("R9 low active", v, 8);
      chk("R11 level irq", 32'(irq_o), 1);
      pin_in = 8'h08; wait_cyc(5);
      rd(4'd8, v); chk("R9 follows", v, 0);
      chk("R11 level irq off", 32'(irq_o), 0);
   endtask

   task automatic t_enable_mask();
      logic [31:0] v;
      quiet();
      wr(4'd7, 8'h10); wr(4'd9, 8'h10);
      pin_in[4] = 1'b1; wait_cyc(6);
      rd(4'd8, v); chk("R10 disabled", v, 0);
      chk("R10 irq", 32'(irq_o), 0);
      pin_in[4] = 1'b0; wait_cyc(4);
      wr(4'd9, 8'h00); wr(4'd5, 8'h10);
      pin_in[4] = 1'b1; wait_cyc(6);
      rd(4'd8, v); chk("R11 pend masked", v, 32'h10);
      chk("R11 masked irq", 32'(irq_o), 0);
      wr(4'd9, 8'h10); wait_cyc(1);
      chk("R11 unmask irq", 32'(irq_o), 1);
   endtask

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
      t_reset();
      t_latch();
      t_dir();
      t_input();
      t_edge_rise();
      t_both_sw();
      t_edge_fall();
      t_level();
      t_enable_mask();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule